// File: doc/BRIEF.md
# Polymorphic Inline Cache Dispatch Unit

This unit sits on a move-triggered datapath and settles a dynamically typed message send in a single clock. Compiled code moves a 32-bit constant into the unit's operand register. That constant holds up to three 10-bit type keys. In the same microword, or a later one, code moves the receiver's type identifier into the trigger port. The unit compares a 10-bit field of the identifier against every key. In the next cycle it tells the instruction cache which of the three words that follow the issuing word to fetch. It also supplies a 16-bit substitute tag taken from the identifier. The cache checks the fetched line's stored tag against this substitute tag instead of its usual (instruction pointer, context) key. A lookalike type therefore ends up as an ordinary cache miss.

If no key matches, the unit raises a one-cycle miss flag, and the cache sequencer sends control to its fallback lookup. The unit is a small state machine with three states. ST_IDLE means no result is presented. ST_HIT presents an offset and a substitute tag. ST_MISS presents the miss flag. From every state the transitions are the same. A trigger whose compare matches goes to ST_HIT (transition T_HIT). A trigger with no match goes to ST_MISS (T_MISS). A cycle without a trigger goes back to ST_IDLE (T_CLEAR).

Top module: `pic_dispatch`

## Requirements
- R1: After reset, `line_ofs` is 0, `tag_sub_en` is 0, `tag_sub` is 0, `pic_miss` is 0, and the stored operand is all zeros, so a trigger without a prior operand write misses.
- R2: `op_wr` loads the operand. Entry 1's key is `op_data[29:20]`, entry 2's key is `op_data[19:10]` and entry 3's key is `op_data[9:0]`. Bits 31:30 are ignored.
- R3: On a trigger, `trig_data[11:2]` is compared with each key. If entry k matches, `line_ofs` = k (1, 2 or 3) in the cycle after the trigger.
- R4: With a hit, `tag_sub_en` is 1 and `tag_sub` equals `trig_data[27:12]` of the trigger, in the same cycle as `line_ofs`.
- R5: A key of all zeros never matches. An identifier whose bits 11:2 are zero therefore always misses.
- R6: If no key matches, `pic_miss` is 1 for the cycle after the trigger, with `line_ofs` = 0 and `tag_sub_en` = 0.
- R7: When several keys match, the lowest-numbered entry is reported.
- R8: Results last exactly one cycle. In a cycle that follows a cycle without a trigger, all outputs are 0.
- R9: When `op_wr` and `trig_wr` are asserted in the same cycle, the compare uses the new `op_data`.
- R10: An operand write without a trigger produces no result in the following cycle.
- R11: Triggers in consecutive cycles produce independent results in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_wr | input | 1 | Operand register write strobe |
| op_data | input | 32 | Packed key constant |
| trig_wr | input | 1 | Trigger write strobe; starts a dispatch |
| trig_data | input | 32 | Receiver type identifier |
| line_ofs | output | 2 | Words past the issuing word to fetch next (0 = none) |
| tag_sub_en | output | 1 | Cache must compare against `tag_sub` for this fetch |
| tag_sub | output | 16 | Substitute tag from identifier bits 27:12 |
| pic_miss | output | 1 | No key matched; take the miss path |

## Verification
Two situations are hard to reach from the ports. The first is a multiple match, which needs an operand with duplicate non-zero keys. The second is an operand written in the same cycle as the trigger, where an old stored operand could hide a wrong select. The bench sweeps all 1024 values of the compare field under several operand patterns: distinct keys, duplicated keys, zero slots and all zeros. In each sweep the operand is rewritten in the trigger cycle after first storing a different operand. A final sweep fires triggers on consecutive cycles to exercise the direct state-to-state transitions.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIT  = 2'd1,
        ST_MISS = 2'd2
    } pic_state_e;

endpackage

// File: rtl/pic_key_match.sv
module pic_key_match #(
    parameter int N_KEYS = 3,
    parameter int KEY_W  = 10
) (
    input  logic [N_KEYS*KEY_W-1:0] keys,
    input  logic [KEY_W-1:0]        field,
    output logic [N_KEYS-1:0]       match
);

    // Entry 1 occupies the most significant key slot.
    for (genvar k = 0; k < N_KEYS; k++) begin : g_cmp
        localparam int HI = (N_KEYS - k) * KEY_W - 1;
        logic [KEY_W-1:0] key;
        assign key      = keys[HI -: KEY_W];
        assign match[k] = (key != '0) && (key == field);
    end

endmodule

// File: rtl/pic_prio_sel.sv
module pic_prio_sel #(
    parameter int N_KEYS = 3,
    parameter int OFS_W  = $clog2(N_KEYS + 1)
) (
    input  logic [N_KEYS-1:0] match,
    output logic [N_KEYS-1:0] grant,
    output logic [OFS_W-1:0]  ofs,
    output logic              any
);

    always_comb begin
        grant = '0;
        ofs   = '0;
        any   = 1'b0;
        for (int i = N_KEYS - 1; i >= 0; i--) begin
            if (match[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                ofs      = OFS_W'(i + 1);
                any      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pic_dispatch.sv
module pic_dispatch
    import pic_pkg::*;
#(
    parameter int ID_W    = 32,
    parameter int N_KEYS  = 3,
    parameter int KEY_W   = 10,
    parameter int KEY_LSB = 2,
    parameter int TAG_W   = 16,
    parameter int TAG_LSB = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_wr,
    input  logic [31:0] op_data,
    input  logic        trig_wr,
    input  logic [31:0] trig_data,
    output logic [1:0]  line_ofs,
    output logic        tag_sub_en,
    output logic [15:0] tag_sub,
    output logic        pic_miss
);

    localparam int KEYS_W = N_KEYS * KEY_W;
    localparam int OFS_W  = $clog2(N_KEYS + 1);
    localparam int TAG_HI = TAG_LSB + TAG_W - 1;

    pic_state_e        state_q, state_d;
    logic [KEYS_W-1:0] opnd_q;
    logic [KEYS_W-1:0] opnd_eff;
    logic [N_KEYS-1:0] match;
    logic [N_KEYS-1:0] grant;
    logic [OFS_W-1:0]  sel_ofs;
    logic              sel_any;
    logic [OFS_W-1:0]  ofs_q;
    logic [TAG_W-1:0]  tag_q;
    logic [KEY_W-1:0]  id_field;
    logic              unused_bits;

    assign unused_bits = ^{op_data[31:KEYS_W], trig_data[KEY_LSB-1:0],
                           trig_data[ID_W-1:TAG_HI+1]};

    // Operand written in the trigger cycle takes effect at once.
    assign opnd_eff = op_wr ? op_data[KEYS_W-1:0] : opnd_q;
    assign id_field = trig_data[KEY_LSB +: KEY_W];

    pic_key_match #(.N_KEYS(N_KEYS), .KEY_W(KEY_W)) u_match (
        .keys  (opnd_eff),
        .field (id_field),
        .match (match)
    );

    pic_prio_sel #(.N_KEYS(N_KEYS), .OFS_W(OFS_W)) u_prio (
        .match (match),
        .grant (grant),
        .ofs   (sel_ofs),
        .any   (sel_any)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opnd_q <= '0;
        end else if (op_wr) begin
            opnd_q <= op_data[KEYS_W-1:0];
        end
    end

    // Next state: T_HIT, T_MISS, T_CLEAR
    always_comb begin
        if (!trig_wr)     state_d = ST_IDLE;
        else if (sel_any) state_d = ST_HIT;
        else              state_d = ST_MISS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ofs_q   <= '0;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            if (trig_wr) begin
                ofs_q <= sel_ofs;
                tag_q <= trig_data[TAG_LSB +: TAG_W];
            end
        end
    end

    always_comb begin
        line_ofs   = '0;
        tag_sub_en = 1'b0;
        tag_sub    = '0;
        pic_miss   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_HIT: begin
                line_ofs   = ofs_q;
                tag_sub_en = 1'b1;
                tag_sub    = tag_q;
            end
            ST_MISS: pic_miss = 1'b1;
            default: ;
        endcase
    end

    // R7: at most one entry is granted
    a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R7: a grant is always the lowest matching entry
    a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> ((match & ((grant << 1) - 1'b1) & ~grant) == '0));

    // R3: a trigger always yields either a hit or a miss next cycle
    a_r3_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        trig_wr |=> (tag_sub_en ^ pic_miss));

    // R4: substitute tag carries the trigger's upper field
    a_r4_tag_source: assert property (@(posedge clk) disable iff (!rst_n)
        trig_wr |=> (!tag_sub_en || tag_sub == $past(trig_data[TAG_HI:TAG_LSB])));

    // R4: a hit always names a following word
    a_r4_hit_has_ofs: assert property (@(posedge clk) disable iff (!rst_n)
        tag_sub_en |-> (line_ofs != '0));

    // R6: a miss carries no offset and no substitute tag
    a_r6_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
        pic_miss |-> (line_ofs == '0 && !tag_sub_en));

    // R8: without a trigger, outputs clear next cycle
    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_wr |=> (line_ofs == '0 && !tag_sub_en && !pic_miss && tag_sub == '0));

endmodule

// File: tb/sim_pic_dispatch.sv
module sim_pic_dispatch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_wr = 1'b0;
    logic [31:0] op_data = '0;
    logic        trig_wr = 1'b0;
    logic [31:0] trig_data = '0;
    logic [1:0]  line_ofs;
    logic        tag_sub_en;
    logic [15:0] tag_sub;
    logic        pic_miss;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    pic_dispatch u0 (
        .clk(clk), .rst_n(rst_n), .op_wr(op_wr), .op_data(op_data),
        .trig_wr(trig_wr), .trig_data(trig_data), .line_ofs(line_ofs),
        .tag_sub_en(tag_sub_en), .tag_sub(tag_sub), .pic_miss(pic_miss)
    );

    function automatic int exp_ofs(input logic [31:0] opnd, input logic [31:0] id);
        for (int k = 1; k <= 3; k++) begin
            logic [9:0] key;
            key = opnd[29 - 10*(k-1) -: 10];
            if (key != 10'd0 && key == id[11:2]) return k;
        end
        return 0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_result(input logic [31:0] opnd, input logic [31:0] id);
        int e;
        e = exp_ofs(opnd, id);
        if (e != 0) begin
            check("R3/R7 line_ofs", {30'd0, line_ofs}, e);
            check("R4 tag_sub_en", {31'd0, tag_sub_en}, 1);
            check("R4 tag_sub", {16'd0, tag_sub}, {16'd0, id[27:12]});
            check("R3 pic_miss", {31'd0, pic_miss}, 0);
        end else begin
            check("R5/R6 pic_miss", {31'd0, pic_miss}, 1);
            check("R6 line_ofs", {30'd0, line_ofs}, 0);
            check("R6 tag_sub_en", {31'd0, tag_sub_en}, 0);
        end
    endtask

    task automatic check_idle(input string req);
        check(req, {13'd0, line_ofs, tag_sub_en, tag_sub, pic_miss}, 0);
    endtask

    function automatic logic [31:0] make_id(input int f);
        logic [15:0] t;
        t = 16'(f * 37) ^ 16'h5A5A;
        return {4'(f), t, 10'(f), 2'(f + 1)};
    endfunction

    // Sweep every field value; operand stored as decoy, rewritten in trigger cycle (R9)
    task automatic sweep(input logic [31:0] opnd, input logic [31:0] decoy);
        for (int f = 0; f < 1024; f++) begin
            logic [31:0] id;
            id = make_id(f);
            @(negedge clk);
            op_wr = 1'b1; op_data = decoy;
            @(negedge clk);
            op_wr = 1'b1; op_data = opnd; trig_wr = 1'b1; trig_data = id;
            @(negedge clk);
            op_wr = 1'b0; trig_wr = 1'b0;
            check_result(opnd, id);       // R9 new operand in effect
            @(negedge clk);
            check_idle("R8 cleared after one cycle");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1 reset outputs");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 idle after reset");
        // R1: stored operand zero -> miss
        trig_wr = 1'b1; trig_data = make_id(5);
        @(negedge clk);
        trig_wr = 1'b0;
        check("R1 zero operand misses", {31'd0, pic_miss}, 1);
        // R10: operand write alone gives no result
        op_wr = 1'b1; op_data = {2'b11, 10'd5, 10'd6, 10'd7};
        @(negedge clk);
        op_wr = 1'b0;
        check_idle("R10 operand write only");
        // R2: stored operand used later, bits 31:30 ignored
        trig_wr = 1'b1; trig_data = make_id(6);
        @(negedge clk);
        trig_wr = 1'b0;
        check("R2 stored key entry 2", {30'd0, line_ofs}, 2);
        @(negedge clk);

        sweep({2'b00, 10'd17, 10'd300, 10'd1023}, {2'b00, 10'd1023, 10'd17, 10'd300});
        sweep({2'b10, 10'd44, 10'd44, 10'd9},     {2'b00, 10'd9, 10'd0, 10'd44});   // R7
        sweep({2'b01, 10'd0, 10'd512, 10'd512},   {2'b00, 10'd512, 10'd1, 10'd2});  // R5 R7
        sweep({2'b00, 10'd0, 10'd0, 10'd0},       {2'b00, 10'd1, 10'd2, 10'd3});    // R5
        sweep({2'b11, 10'd1, 10'd2, 10'd3},       32'd0);

        // R11: triggers on consecutive cycles
        begin
            logic [31:0] opnd;
            logic [31:0] prev;
            opnd = {2'b00, 10'd100, 10'd200, 10'd300};
            @(negedge clk);
            op_wr = 1'b1; op_data = opnd;
            @(negedge clk);
            op_wr = 1'b0;
            prev = make_id(0);
            trig_wr = 1'b1; trig_data = prev;
            for (int f = 1; f < 1024; f++) begin
                @(negedge clk);
                check_result(opnd, prev);   // R11
                prev = make_id((f * 100) % 1024);
                trig_data = prev;
            end
            @(negedge clk);
            trig_wr = 1'b0;
            check_result(opnd, prev);
            @(negedge clk);
            check_idle("R8 R11 clear after burst");
        end
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule